// File: doc/BRIEF.md
# Control Transfer SETUP and Status Stage Handler

This block serves the SETUP stage and the status stage of control transfers on endpoint 0 of a USB device controller. The packet engine marks the start of a SETUP packet and then delivers its payload one byte at a time. The block keeps the eight payload bytes in a dedicated buffer. Once the eighth byte is stored, it raises a setup-data-available interrupt to firmware and forces the endpoint-0 data toggles so that the following data stage starts with DATA1.

Firmware reads the request through one register location. Each read returns the next byte of the request, and the pointer wraps back to the first byte after the last one. Firmware decides when the control transfer may finish. Until it sets the acknowledge-status bit, every status-stage token is answered with NAK. The first status-stage token after the bit is set is answered with ACK, and the bit then clears itself. A new SETUP packet is always accepted. It replaces the stored request, restarts the read pointer and cancels a pending acknowledge.

Top module: `ctl_setup_stage`

## Requirements
- R1: After reset, `setup_irq`, `ack_pending`, `hs_valid`, `hs_ack`, `hs_nak` and `ep0_tog_force` are all 0.
- R2: In the cycle after the eighth payload byte following `rx_setup_start` is accepted, `setup_irq` reads 1. Payload byte k (k = 0..7) is the k-th byte with `rx_valid` high after the start pulse.
- R3: While `fw_rd` is high, `fw_rd_data` shows the stored byte at the read pointer, and the pointer advances by one at that clock edge. Eight reads return bytes 0..7 in order, and the ninth read returns byte 0 again.
- R4: Writing `fw_irq_clr` = 1 clears `setup_irq` in the next cycle. The write has no effect while the bit is already 0. When a SETUP completes in the same cycle as the clear, the bit stays set.
- R5: A status-stage token (`stat_tok`) that arrives while `ack_pending` is 0 produces, in the next cycle, `hs_valid` = 1 with `hs_nak` = 1 and `hs_ack` = 0.
- R6: `fw_ack_set` sets `ack_pending`. The next status-stage token is answered with `hs_ack` = 1, `hs_nak` = 0, and `ack_pending` clears at the same edge. A later token is answered with NAK again.
- R7: A new SETUP packet overwrites all eight stored bytes, returns the read pointer to byte 0 even in the middle of a read sequence, and clears `ack_pending`.
- R8: `ep0_tog_force` is high for exactly one cycle, the cycle after the eighth payload byte is stored, and it is low at all other times.
- R9: Payload bytes that arrive after the eighth one and before the next `rx_setup_start` are ignored. They change no stored byte and raise neither `setup_irq` nor `ep0_tog_force`.
- R10: `hs_valid` is high only in the cycle after a `stat_tok`, and exactly one of `hs_ack` and `hs_nak` is then 1. Both are 0 when `hs_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_setup_start | input | 1 | Pulse: a SETUP token was received and its payload follows |
| rx_valid | input | 1 | A payload byte is present on `rx_byte` |
| rx_byte | input | DW | Payload byte |
| stat_tok | input | 1 | Pulse: status-stage token (zero-length IN or OUT) to answer |
| fw_rd | input | 1 | Firmware read strobe of the request-byte register |
| fw_rd_data | output | DW | Stored byte at the read pointer |
| fw_irq_clr | input | 1 | Firmware writes 1 to clear the setup-data-available bit |
| fw_ack_set | input | 1 | Firmware sets the acknowledge-status bit |
| setup_irq | output | 1 | Setup-data-available interrupt bit |
| ack_pending | output | 1 | Acknowledge-status bit as firmware reads it |
| hs_valid | output | 1 | A handshake decision is presented |
| hs_ack | output | 1 | Answer the status token with ACK |
| hs_nak | output | 1 | Answer the status token with NAK |
| ep0_tog_force | output | 1 | One-cycle pulse: force endpoint-0 toggles so the next data stage uses DATA1 |

## Verification
The bench builds the block with its default sizes: an eight-byte request buffer and eight-bit bytes. These match the fixed SETUP payload length. With them the bench can reach the read-pointer wrap after the eighth read, the overflow of payload bytes beyond the eighth, and the same-cycle collision between SETUP completion and a firmware interrupt clear. Because the bytes are eight bits wide, every stored byte can carry a distinct value, so any overwritten or reordered byte shows up on the read port.

// File: rtl/ctl_setup_pkg.sv
package ctl_setup_pkg;

    localparam int unsigned SETUP_BYTES = 8;
    localparam int unsigned BYTE_W      = 8;

    typedef struct packed {
        logic irq;
        logic tog;
    } top_state_t;

    typedef struct packed {
        logic ack;
        logic hs_valid;
        logic hs_ack;
    } stat_state_t;

endpackage

// File: rtl/ctl_setup_buf.sv
module ctl_setup_buf #(
    parameter int unsigned BYTES = 8,
    parameter int unsigned DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          done
);

    localparam int unsigned PW = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam int unsigned CW = $clog2(BYTES + 1);

    typedef struct packed {
        logic [BYTES-1:0][DW-1:0] mem;
        logic [CW-1:0]            wcnt;
        logic [PW-1:0]            rp;
        logic                     active;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        done  = 1'b0;
        if (start) begin
            buf_d.wcnt   = '0;
            buf_d.active = 1'b1;
        end else if (wr_en && buf_q.active) begin
            buf_d.mem[buf_q.wcnt[PW-1:0]] = wr_data;
            buf_d.wcnt = buf_q.wcnt + 1'b1;
            if (buf_q.wcnt == CW'(BYTES - 1)) begin
                buf_d.active = 1'b0;
                done         = 1'b1;
            end
        end
        if (rd_en) begin
            buf_d.rp = (buf_q.rp == PW'(BYTES - 1)) ? '0 : buf_q.rp + 1'b1;
        end
        if (done) begin
            buf_d.rp = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign rd_data = buf_q.mem[buf_q.rp];

    // R7: a completed SETUP restarts the read sequence at byte 0
    assert_rdptr_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (buf_q.rp == '0));

    // R9: once full and not restarted, stored bytes never move
    assert_full_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_q.active && !start) |=> $stable(buf_q.mem));

    // R3: a read with no completion advances the pointer by one (mod BYTES)
    assert_rd_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !done && buf_q.rp != PW'(BYTES - 1)) |=> (buf_q.rp == $past(buf_q.rp) + 1'b1));

endmodule

// File: rtl/ctl_setup_status.sv
module ctl_setup_status
    import ctl_setup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tok,
    input  logic ack_set,
    input  logic cancel,
    output logic ack_pending,
    output logic hs_valid,
    output logic hs_ack,
    output logic hs_nak
);

    stat_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.hs_valid = tok;
        st_d.hs_ack   = tok && st_q.ack;
        if (tok && st_q.ack) begin
            st_d.ack = 1'b0;
        end
        if (ack_set) begin
            st_d.ack = 1'b1;
        end
        if (cancel) begin
            st_d.ack = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_pending = st_q.ack;
    assign hs_valid    = st_q.hs_valid;
    assign hs_ack      = st_q.hs_valid && st_q.hs_ack;
    assign hs_nak      = st_q.hs_valid && !st_q.hs_ack;

    // R5: no acknowledge armed -> NAK next cycle
    assert_nak_unarmed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tok && !st_q.ack) |=> (hs_valid && hs_nak));

    // R6: an acknowledged token consumes the armed bit
    assert_ack_selfclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tok && st_q.ack && !ack_set) |=> (hs_ack && !ack_pending));

    // R10: exactly one handshake kind when valid, none otherwise
    assert_hs_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid ? ($countones({hs_ack, hs_nak}) == 1) : ({hs_ack, hs_nak} == 2'b00));

endmodule

// File: rtl/ctl_setup_stage.sv
module ctl_setup_stage
    import ctl_setup_pkg::*;
#(
    parameter int unsigned BYTES = SETUP_BYTES,
    parameter int unsigned DW    = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_setup_start,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic          stat_tok,
    input  logic          fw_rd,
    output logic [DW-1:0] fw_rd_data,
    input  logic          fw_irq_clr,
    input  logic          fw_ack_set,
    output logic          setup_irq,
    output logic          ack_pending,
    output logic          hs_valid,
    output logic          hs_ack,
    output logic          hs_nak,
    output logic          ep0_tog_force
);

    logic       setup_done;
    top_state_t top_d, top_q;

    ctl_setup_buf #(
        .BYTES (BYTES),
        .DW    (DW)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (rx_setup_start),
        .wr_en   (rx_valid),
        .wr_data (rx_byte),
        .rd_en   (fw_rd),
        .rd_data (fw_rd_data),
        .done    (setup_done)
    );

    ctl_setup_status u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .tok         (stat_tok),
        .ack_set     (fw_ack_set),
        .cancel      (setup_done),
        .ack_pending (ack_pending),
        .hs_valid    (hs_valid),
        .hs_ack      (hs_ack),
        .hs_nak      (hs_nak)
    );

    always_comb begin
        top_d     = top_q;
        top_d.tog = setup_done;
        if (fw_irq_clr) begin
            top_d.irq = 1'b0;
        end
        if (setup_done) begin
            top_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign setup_irq     = top_q.irq;
    assign ep0_tog_force = top_q.tog;

    // R2: completed payload raises the interrupt bit
    assert_irq_on_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        setup_done |=> setup_irq);

    // R4: a clear with no completion drops the bit
    assert_irq_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_irq_clr && !setup_done) |=> !setup_irq);

    // R8: toggle force is a single-cycle pulse
    assert_tog_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ep0_tog_force |=> !ep0_tog_force);

    // R7: completion cancels a pending acknowledge
    assert_cancel_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        setup_done |=> !ack_pending);

endmodule

// File: tb/ctl_setup_stage_tb.sv
module ctl_setup_stage_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_setup_start = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       stat_tok = 1'b0;
    logic       fw_rd = 1'b0;
    logic [7:0] fw_rd_data;
    logic       fw_irq_clr = 1'b0;
    logic       fw_ack_set = 1'b0;
    logic       setup_irq, ack_pending, hs_valid, hs_ack, hs_nak, ep0_tog_force;

    int n_tests = 0;
    int n_fail  = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    ctl_setup_stage u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_setup_start (rx_setup_start),
        .rx_valid       (rx_valid),
        .rx_byte        (rx_byte),
        .stat_tok       (stat_tok),
        .fw_rd          (fw_rd),
        .fw_rd_data     (fw_rd_data),
        .fw_irq_clr     (fw_irq_clr),
        .fw_ack_set     (fw_ack_set),
        .setup_irq      (setup_irq),
        .ack_pending    (ack_pending),
        .hs_valid       (hs_valid),
        .hs_ack         (hs_ack),
        .hs_nak         (hs_nak),
        .ep0_tog_force  (ep0_tog_force)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drives a SETUP start then eight bytes; returns at the observation point
    task automatic send_setup(input logic [63:0] pl, input bit clr_on_last);
        rx_setup_start = 1'b1;
        @(negedge clk);
        rx_setup_start = 1'b0;
        for (int i = 0; i < 8; i++) begin
            rx_valid   = 1'b1;
            rx_byte    = pl[8*i +: 8];
            fw_irq_clr = clr_on_last && (i == 7);
            @(negedge clk);
        end
        rx_valid   = 1'b0;
        fw_irq_clr = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [7:0] exp);
        fw_rd = 1'b1;
        check(req, fw_rd_data, exp);
        @(negedge clk);
        fw_rd = 1'b0;
    endtask

    task automatic pulse_tok();
        stat_tok = 1'b1;
        @(negedge clk);
        stat_tok = 1'b0;
    endtask

    task automatic clear_irq();
        fw_irq_clr = 1'b1;
        @(negedge clk);
        fw_irq_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 irq", setup_irq, 0);
        check("R1 ack_pending", ack_pending, 0);
        check("R1 hs", {hs_valid, hs_ack, hs_nak}, 0);
        check("R1 tog", ep0_tog_force, 0);
    endtask

    task automatic t_capture_read();
        logic [63:0] pl = 64'h0807_0605_0403_0201 ^ 64'hA050_3C00_1188_7700;
        send_setup(pl, 1'b0);
        check("R2 irq raised", setup_irq, 1);
        check("R8 tog pulse", ep0_tog_force, 1);
        @(negedge clk);
        check("R8 tog one cycle", ep0_tog_force, 0);
        for (int i = 0; i < 8; i++) read_check("R3 read order", pl[8*i +: 8]);
        read_check("R3 wrap", pl[7:0]);
        check("R10 no hs without token", hs_valid, 0);
    endtask

    task automatic t_irq_clear();
        clear_irq();
        check("R4 clear", setup_irq, 0);
        clear_irq();
        check("R4 clear while 0", setup_irq, 0);
        send_setup(64'h1122_3344_5566_7788, 1'b1);
        check("R4 set wins over clear", setup_irq, 1);
        clear_irq();
    endtask

    task automatic t_status();
        pulse_tok();
        check("R5 nak valid", hs_valid, 1);
        check("R5 nak", {hs_ack, hs_nak}, 2'b01);
        @(negedge clk);
        check("R10 hs idle", {hs_valid, hs_ack, hs_nak}, 0);
        fw_ack_set = 1'b1;
        @(negedge clk);
        fw_ack_set = 1'b0;
        check("R6 ack_pending set", ack_pending, 1);
        pulse_tok();
        check("R6 ack", {hs_valid, hs_ack, hs_nak}, 3'b110);
        check("R6 self clear", ack_pending, 0);
        pulse_tok();
        check("R6 nak after ack", {hs_valid, hs_ack, hs_nak}, 3'b101);
    endtask

    task automatic t_overwrite();
        logic [63:0] pa = 64'hF1E2_D3C4_B5A6_9788;
        logic [63:0] pb = 64'h0F1E_2D3C_4B5A_6978;
        send_setup(pa, 1'b0);
        clear_irq();
        for (int i = 0; i < 3; i++) read_check("R3 partial read", pa[8*i +: 8]);
        fw_ack_set = 1'b1;
        @(negedge clk);
        fw_ack_set = 1'b0;
        send_setup(pb, 1'b0);
        check("R7 ack cancelled", ack_pending, 0);
        check("R7 irq", setup_irq, 1);
        for (int i = 0; i < 8; i++) read_check("R7 new bytes", pb[8*i +: 8]);
        clear_irq();
        // R9: extra bytes past the eighth
        for (int i = 0; i < 3; i++) begin
            rx_valid = 1'b1;
            rx_byte  = 8'hEE;
            @(negedge clk);
            check("R9 no tog on extra", ep0_tog_force, 0);
        end
        rx_valid = 1'b0;
        check("R9 no irq on extra", setup_irq, 0);
        for (int i = 0; i < 8; i++) read_check("R9 bytes unchanged", pb[8*i +: 8]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_capture_read();
        t_irq_clear();
        t_status();
        t_overwrite();
        done_flag = 1'b1;
    end

    initial begin
        fork
            wait (done_flag);
            begin
                repeat (20000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule